// File: doc/BRIEF.md
# Skewed-Feed Systolic Matrix-Vector Array

The block multiplies a 4×10 coefficient matrix by a 10×10 sample tile and returns the 4×10 product. The tile is banded: its row k, column j holds sample x[k+j]. A single 19-sample stream therefore describes the whole tile. The array has ten element rows, one per output column j, and four elements in each row, one per filter. Samples enter at the bottom row and climb one row per clock. Coefficients for all four filters arrive as one unskewed stream. An internal zero-insertion shift chain delays that stream by two extra cycles for each row up the array. Row j then meets coefficient k together with sample x[k+j], and each element accumulates its own output in place.

A one-cycle `load` pulse starts a run. On the load cycle `data_in` carries x[0] and `coef_in` carries coefficient 0 of every filter. The next 18 cycles carry x[1]..x[18], and the next 9 of those cycles also carry coefficients 1..9. Results are latched into an output bank that holds a valid flag for each result. `done` rises once all forty results are held. A new `load` pulse at any time discards the run in progress and starts a new one.

Top module: `sysmv_array`

## Requirements
- R1: For filter f (0..3) and output column j (0..9), the result equals the sum over k = 0..9 of W[f][k]·x[k+j], taken modulo 2^20. Coefficient W[f][k] is bits [20f+19:20f] of `coef_in` on cycle k after load, where the load cycle is cycle 0. Sample x[s] is `data_in` on cycle s.
- R2: Inputs outside their windows have no effect. This covers `coef_in` on cycles 10 and later, `data_in` on cycles 19 and later, and both inputs when no run is active.
- R3: The flag of output column j rises exactly 2j+11 clock edges after the load edge, so the bottom row comes first and each row above follows two cycles later. The result and flag for filter f, column j sit at index i = 4j+f: bits [20i+19:20i] of `result` and bit i of `res_valid`.
- R4: The four filters are computed independently. A filter whose coefficients are all zero yields zero in every column while the other filters keep their own sums.
- R5: A load pulse clears every flag and `done` on its edge. A load that arrives while a run is in flight, including on the very edge where a result would be captured, leaves no result of the old run behind.
- R6: `done` is high exactly when all forty flags are high, which is 29 edges after the load edge.
- R7: After reset every flag and `done` are low.
- R8: Once captured, results, flags and `done` hold unchanged until the next load.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| load | input | 1 | One-cycle pulse that starts or restarts a run |
| data_in | input | 20 | Sample stream x[0..18] |
| coef_in | input | 80 | Four coefficients per cycle, filter f at bits [20f+19:20f] |
| result | output | 800 | Result bank, entry i = 4j+f at bits [20i+19:20i] |
| res_valid | output | 40 | Captured flag for each result entry |
| done | output | 1 | All forty results captured |

## Verification
The collision that matters is a restart that lands on the same edge as a result capture. Both the flag clear and the capture of a row's sum want to update the same bank entry. The bench provokes this by pulsing load exactly eleven edges after a previous load, when bottom-row results would otherwise latch, and again mid-run while upper rows are still accumulating. A reference model reset by the new load expects every flag to be low after that edge. It also expects the new run's results to match a freshly computed product at the 2j+11 timetable, so any stale capture or leftover partial sum shows up as a flag or value mismatch.

// File: rtl/sysmv_pkg.sv
package sysmv_pkg;
  // Control token travelling beside the coefficient stream
  typedef struct packed {
    logic vld;    // coefficient slot carries real data
    logic first;  // slot k = 0: restart the accumulation
    logic last;   // slot k = TAPS-1: sum complete after this slot
  } tag_t;
endpackage

// File: rtl/sysmv_skew.sv
module sysmv_skew
  import sysmv_pkg::*;
#(
  parameter int ROWS = 10,
  parameter int FILT = 4,
  parameter int CW   = 20
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 flush,
  input  tag_t                 tag_in,
  input  logic [FILT*CW-1:0]   w_in,
  output tag_t                 tag_row [ROWS],
  output logic [FILT*CW-1:0]   w_row   [ROWS]
);
  // Row r taps stage 2r: total delay 2r+1, so each row lags the one below by two slots
  localparam int STG = 2*ROWS - 1;

  tag_t               tq [STG];
  logic [FILT*CW-1:0] wq [STG];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STG; i++) tq[i] <= '0;
    end else begin
      tq[0] <= tag_in;
      for (int i = 1; i < STG; i++) tq[i] <= flush ? '0 : tq[i-1];
    end
  end

  // Zero insertion: idle slots carry zero coefficients
  always_ff @(posedge clk) begin
    wq[0] <= tag_in.vld ? w_in : '0;
    for (int i = 1; i < STG; i++) wq[i] <= wq[i-1];
  end

  for (genvar r = 0; r < ROWS; r++) begin : g_tap
    assign tag_row[r] = tq[2*r];
    assign w_row[r]   = wq[2*r];
  end

  // Idle slots must present zero coefficients to the rows (R2)
  for (genvar r = 0; r < ROWS; r++) begin : g_chk
    p_idle_zero_r2: assert property (@(posedge clk) disable iff (rst)
      (!tag_row[r].vld && $past(!tag_in.vld, 2*r+1)) |-> (w_row[r] == '0));
  end
endmodule

// File: rtl/sysmv_pe.sv
module sysmv_pe
  import sysmv_pkg::*;
#(
  parameter int DW = 20,
  parameter int CW = 20,
  parameter int OW = 20
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          flush,
  input  logic [DW-1:0] x,
  input  logic [CW-1:0] w,
  input  tag_t          tag,
  output logic [OW-1:0] y,
  output logic          stb
);
  localparam int PW = DW + CW;

  logic [PW-1:0] prod;
  logic [OW-1:0] acc, sum;

  always_comb begin
    prod = {{CW{1'b0}}, x} * {{DW{1'b0}}, w};
    sum  = (tag.first ? '0 : acc) + prod[OW-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc <= '0;
      y   <= '0;
      stb <= 1'b0;
    end else begin
      stb <= 1'b0;
      if (tag.vld) acc <= sum;
      if (tag.vld && tag.last && !flush) begin
        y   <= sum;
        stb <= 1'b1;
      end
    end
  end

  // A first slot starts a fresh sum from its own product alone (R1)
  p_first_restart_r1: assert property (@(posedge clk) disable iff (rst)
    (tag.vld && tag.first) |=> (acc == $past(prod[OW-1:0])));
endmodule

// File: rtl/sysmv_collect.sv
module sysmv_collect #(
  parameter int ROWS = 10,
  parameter int FILT = 4,
  parameter int OW   = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     flush,
  input  logic [OW-1:0]            y_in [ROWS*FILT],
  input  logic [ROWS*FILT-1:0]     stb_in,
  output logic [ROWS*FILT*OW-1:0]  result,
  output logic [ROWS*FILT-1:0]     flags,
  output logic                     done
);
  localparam int NR = ROWS * FILT;

  logic [OW-1:0] bank [NR];
  logic [NR-1:0] nxt;

  assign nxt = flags | stb_in;

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      flags <= '0;
      done  <= 1'b0;
    end else begin
      flags <= nxt;
      done  <= &nxt;
    end
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NR; i++)
      if (stb_in[i] && !flush) bank[i] <= y_in[i];
  end

  for (genvar i = 0; i < NR; i++) begin : g_out
    assign result[i*OW +: OW] = bank[i];
  end

  // Captured flags stay set until a restart (R8)
  p_flags_sticky_r8: assert property (@(posedge clk) disable iff (rst)
    !flush |=> ((flags & $past(flags)) == $past(flags)));
endmodule

// File: rtl/sysmv_array.sv
module sysmv_array
  import sysmv_pkg::*;
#(
  parameter int ROWS = 10,
  parameter int TAPS = 10,
  parameter int FILT = 4,
  parameter int DW   = 20,
  parameter int CW   = 20,
  parameter int OW   = 20
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     load,
  input  logic [DW-1:0]            data_in,
  input  logic [FILT*CW-1:0]       coef_in,
  output logic [ROWS*FILT*OW-1:0]  result,
  output logic [ROWS*FILT-1:0]     res_valid,
  output logic                     done
);
  localparam int NR    = ROWS * FILT;
  localparam int CNT_W = $clog2(TAPS + 1);

  logic [CNT_W-1:0]   cnt;
  tag_t               tag_in;
  tag_t               tag_row [ROWS];
  logic [FILT*CW-1:0] w_row   [ROWS];
  logic [DW-1:0]      xq      [ROWS];
  logic [OW-1:0]      pe_y    [NR];
  logic [NR-1:0]      pe_stb;

  // Slot counter: load is slot 0, then slots 1..TAPS-1
  always_ff @(posedge clk) begin
    if (rst)                                           cnt <= '0;
    else if (load)                                     cnt <= (TAPS > 1) ? CNT_W'(1) : '0;
    else if (cnt != '0 && cnt < CNT_W'(TAPS - 1))      cnt <= cnt + 1'b1;
    else                                               cnt <= '0;
  end

  always_comb begin
    tag_in.vld   = load || (cnt != '0);
    tag_in.first = load;
    tag_in.last  = load ? (TAPS == 1) : (cnt == CNT_W'(TAPS - 1));
  end

  // Samples climb one row per clock
  always_ff @(posedge clk) begin
    xq[0] <= data_in;
    for (int r = 1; r < ROWS; r++) xq[r] <= xq[r-1];
  end

  sysmv_skew #(.ROWS(ROWS), .FILT(FILT), .CW(CW)) u_skew (
    .clk(clk), .rst(rst), .flush(load),
    .tag_in(tag_in), .w_in(coef_in),
    .tag_row(tag_row), .w_row(w_row)
  );

  for (genvar r = 0; r < ROWS; r++) begin : g_row
    for (genvar f = 0; f < FILT; f++) begin : g_flt
      sysmv_pe #(.DW(DW), .CW(CW), .OW(OW)) u_pe (
        .clk(clk), .rst(rst), .flush(load),
        .x(xq[r]), .w(w_row[r][f*CW +: CW]), .tag(tag_row[r]),
        .y(pe_y[r*FILT+f]), .stb(pe_stb[r*FILT+f])
      );
    end
  end

  sysmv_collect #(.ROWS(ROWS), .FILT(FILT), .OW(OW)) u_coll (
    .clk(clk), .rst(rst), .flush(load),
    .y_in(pe_y), .stb_in(pe_stb),
    .result(result), .flags(res_valid), .done(done)
  );

  // Restart clears every flag and done on its edge (R5)
  p_clear_on_load_r5: assert property (@(posedge clk) disable iff (rst)
    load |=> (res_valid == '0 && !done));

  // done only with the full bank (R6)
  p_done_full_r6: assert property (@(posedge clk) disable iff (rst)
    done |-> (&res_valid));

  for (genvar r = 0; r < ROWS; r++) begin : g_chk
    // All filters of a row finish together (R4)
    p_filters_lockstep_r4: assert property (@(posedge clk) disable iff (rst)
      ($countones(pe_stb[r*FILT +: FILT]) == 0) ||
      ($countones(pe_stb[r*FILT +: FILT]) == FILT));
    if (r > 0) begin : g_lag
      // Each row completes two cycles after the row below (R3)
      p_row_lag_r3: assert property (@(posedge clk) disable iff (rst)
        pe_stb[r*FILT] |-> $past(pe_stb[(r-1)*FILT], 2));
    end
  end
endmodule

// File: tb/tb_sysmv_array.sv
module tb_sysmv_array;
  localparam int ROWS = 10, TAPS = 10, FILT = 4, DW = 20, CW = 20, OW = 20;
  localparam int NX = TAPS + ROWS - 1;
  localparam int NR = ROWS * FILT;
  localparam longint MASK = (64'd1 << OW) - 1;

  logic clk = 1'b0;
  logic rst, load;
  logic [DW-1:0]           data_in;
  logic [FILT*CW-1:0]      coef_in;
  logic [ROWS*FILT*OW-1:0] result;
  logic [NR-1:0]           res_valid;
  logic                    done;

  always #10 clk = ~clk;

  sysmv_array dut (
    .clk(clk), .rst(rst), .load(load), .data_in(data_in), .coef_in(coef_in),
    .result(result), .res_valid(res_valid), .done(done)
  );

  int checks = 0, errors = 0;
  longint nx [NX];
  longint nw [FILT][TAPS];
  longint ex_x [NX];
  longint ex_w [FILT][TAPS];
  int age = -1;
  int pos = -1;
  bit garb = 1'b0;
  string vtag = "R1";

  function automatic longint expy(int f, int j);
    longint s = 0;
    for (int k = 0; k < TAPS; k++) s += ex_w[f][k] * ex_x[k+j];
    return s & MASK;
  endfunction

  task automatic check(bit ok, string req, longint act, longint expv, string what);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
    end
  endtask

  task automatic compare();
    for (int i = 0; i < NR; i++) begin
      int j = i / FILT;
      int f = i % FILT;
      bit ef = (age >= 0) && (age >= 2*j + 11);
      check(res_valid[i] == ef, "R3", res_valid[i], ef, $sformatf("flag %0d", i));
      if (ef && res_valid[i])
        check(longint'(result[i*OW +: OW]) == expy(f, j), vtag,
              result[i*OW +: OW], expy(f, j), $sformatf("result f%0d j%0d", f, j));
    end
    check(done == ((age >= 0) && (age >= 2*(ROWS-1) + 11)), "R6", done,
          (age >= 2*(ROWS-1) + 11), "done");
  endtask

  task automatic tick(bit ld);
    load = ld;
    if (ld) pos = 0; else if (pos >= 0) pos++;
    if (pos >= 0 && pos < NX) data_in = DW'(nx[pos]);
    else data_in = garb ? DW'($urandom) : '0;
    for (int f = 0; f < FILT; f++)
      coef_in[f*CW +: CW] = (pos >= 0 && pos < TAPS) ? CW'(nw[f][pos]) :
                            (garb ? CW'($urandom) : '0);
    @(posedge clk);
    if (ld) begin
      age = 0;
      ex_x = nx;
      ex_w = nw;
    end else if (age >= 0) age++;
    @(negedge clk);
    compare();
  endtask

  task automatic fill(int lim, int zero_f);
    for (int s = 0; s < NX; s++)
      nx[s] = (lim < 0) ? longint'($urandom) & MASK : longint'($urandom_range(lim));
    for (int f = 0; f < FILT; f++)
      for (int k = 0; k < TAPS; k++)
        nw[f][k] = (f == zero_f) ? 0 :
                   ((lim < 0) ? longint'($urandom) & MASK : longint'($urandom_range(lim)));
  endtask

  task automatic summary();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired, run did not complete");
    summary();
    $finish;
  end

  initial begin
    rst = 1'b1; load = 1'b0; data_in = '0; coef_in = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    check(res_valid == '0, "R7", res_valid, 0, "flags after reset");
    check(done == 1'b0, "R7", done, 0, "done after reset");
    tick(0); tick(0);

    // Plain run, small values
    fill(32, -1); garb = 1'b0; vtag = "R1";
    tick(1); repeat (34) tick(0);

    // Garbage outside windows, then a long hold
    fill(32, -1); garb = 1'b1; vtag = "R2";
    tick(1); repeat (45) tick(0);
    check(done == 1'b1, "R8", done, 1, "done held long after run");
    for (int i = 0; i < NR; i++)
      check(longint'(result[i*OW +: OW]) == expy(i % FILT, i / FILT), "R8",
            result[i*OW +: OW], expy(i % FILT, i / FILT), "held result");

    // Full-width values: modulo wrap
    fill(-1, -1); vtag = "R1";
    tick(1); repeat (32) tick(0);

    // One filter all zero
    fill(32, 2); vtag = "R4";
    tick(1); repeat (32) tick(0);
    for (int j = 0; j < ROWS; j++)
      check(result[(j*FILT+2)*OW +: OW] == '0, "R4",
            result[(j*FILT+2)*OW +: OW], 0, "zero filter result");

    // Mid-run restart while upper rows accumulate
    fill(32, -1); vtag = "R5";
    tick(1); repeat (14) tick(0);
    fill(32, -1);
    tick(1);
    check(res_valid == '0, "R5", res_valid, 0, "flags after mid-run restart");
    repeat (32) tick(0);

    // Restart on the edge of the first capture
    fill(32, -1);
    tick(1); repeat (10) tick(0);
    fill(32, -1);
    tick(1);
    check(res_valid == '0, "R5", res_valid, 0, "flags after colliding restart");
    check(done == 1'b0, "R5", done, 0, "done after colliding restart");
    repeat (32) tick(0);

    summary();
    $finish;
  end
endmodule